// File: doc/BRIEF.md
# Tag Store with Pipelined Equality Check

This block is a single-port, synchronous tag memory with a comparator built in. Each clock edge captures an address, a tag word, a write strobe, a data-load enable and a pair of select lines. A selected cycle reads a stored tag, writes one, or compares the held tag against the entry at the held address. The compare result passes through one pipeline register before it reaches the match pin. Two combinational enables gate the data and match outputs. A gated output is shown as a low valid flag with the value forced to zero, which stands for high impedance.

A cache controller uses it as the tag directory. It loads the lookup tag together with the index, and one edge later it reads hit or miss. On a refill it writes the new tag, either from fresh input or from the tag already held, so the tag does not have to be presented again. The outputs have no ready input and cannot be stalled. A data word is valid for as long as its output enable is low. It stays fixed until the next read lands. The match value is renewed on every edge, so the consumer must take it on the cycle it is wanted.

Top module: `tag_cache_ram`

## Requirements
- R1: The block is selected only when `sel_n` is 0 and `sel_hi` is 1. On an edge where it is not selected, the address register keeps its value and no read or write is issued, so the array and the data output are left alone.
- R2: The tag register takes `din` only on an edge where the block is selected and `load_n` is 0. On every other edge it keeps its value.
- R3: A selected edge with `wr_n` 0 schedules a write. On the next edge, the tag register value is stored at the registered address.
- R4: A write with `load_n` 1 (fill) stores the tag already held in the register, and `din` is ignored.
- R5: On every edge, the match register captures whether the tag register equals the array word at the registered address. A compare issued on edge k therefore shows on `match` after edge k+1, with 1 for equal and 0 for unequal.
- R6: A selected edge with `wr_n` 1 schedules a read. On the next edge the output register takes the array word at the registered address. Otherwise the output register keeps its value.
- R7: `dout_vld` is the inverse of `oe_n`, with no clock in between. While `oe_n` is 1, `dout` is 0.
- R8: `match_vld` is the inverse of `match_oe_n`, with no clock in between. While `match_oe_n` is 1, `match` is 0. The match result is still shown during deselected cycles.
- R9: Synchronous reset (`rst` 1) clears the match register and the output register to 0 and cancels any pending operation. Array contents and the held tag and address are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers use the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Entry index, captured when selected |
| din | input | DATA_W | Tag input, captured when selected and `load_n` is 0 |
| wr_n | input | 1 | 0 selects a write, 1 a read |
| sel_n | input | 1 | Active-low select |
| sel_hi | input | 1 | Active-high select |
| load_n | input | 1 | Active-low load enable for the tag register |
| oe_n | input | 1 | Active-low data output enable, combinational |
| match_oe_n | input | 1 | Active-low match output enable, combinational |
| dout | output | DATA_W | Output register value, 0 when gated |
| dout_vld | output | 1 | High while `dout` is driven |
| match | output | 1 | Registered compare result, 0 when gated |
| match_vld | output | 1 | High while `match` is driven |

## Verification
A tag register that is corrupted or fails to hold shows up as a wrong `match` on the edge after the next compare. That is the earliest point a port can reveal it. A write that lands at the wrong address or one cycle late shows up only when that entry is read back or compared. The bench therefore follows every write with reads and compares of nearby entries, and it checks both outputs on every cycle against a reference array. A stuck output register or a wrong pending-operation decode shows on `dout` one edge after the read that should have refreshed it.

// File: rtl/tag_pkg.sv
package tag_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } tag_op_e;

  function automatic logic chip_selected(input logic sel_n, input logic sel_hi);
    return !sel_n && sel_hi;
  endfunction

endpackage

// File: rtl/tag_input_regs.sv
module tag_input_regs
  import tag_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          wr_n,
  input  logic          sel_n,
  input  logic          sel_hi,
  input  logic          load_n,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] din_q,
  output tag_op_e       op_q
);

  logic sel;
  assign sel = chip_selected(sel_n, sel_hi);

  // Address and tag hold through reset; only the pending operation is cleared.
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q <= OP_IDLE;
    end else begin
      if (sel) addr_q <= addr;
      if (sel && !load_n) din_q <= din;
      if (!sel)      op_q <= OP_IDLE;
      else if (wr_n) op_q <= OP_READ;
      else           op_q <= OP_WRITE;
    end
  end

endmodule

// File: rtl/tag_store.sv
module tag_store #(
  parameter int AW = 6,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rword
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rword = cells[addr];

endmodule

// File: rtl/tag_compare.sv
module tag_compare #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] key,
  input  logic [DW-1:0] word,
  output logic          hit_q
);

  logic [DW-1:0] bit_eq;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign bit_eq[b] = ~(key[b] ^ word[b]);
  end

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= &bit_eq;
  end

endmodule

// File: rtl/tag_cache_ram.sv
module tag_cache_ram
  import tag_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              wr_n,
  input  logic              sel_n,
  input  logic              sel_hi,
  input  logic              load_n,
  input  logic              oe_n,
  input  logic              match_oe_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_vld,
  output logic              match,
  output logic              match_vld
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q;
  tag_op_e           op_q;
  logic [DATA_W-1:0] rword;
  logic              hit_q;
  logic [DATA_W-1:0] dout_q;

  tag_input_regs #(.AW(ADDR_W), .DW(DATA_W)) u_in (
    .clk    (clk),
    .rst    (rst),
    .addr   (addr),
    .din    (din),
    .wr_n   (wr_n),
    .sel_n  (sel_n),
    .sel_hi (sel_hi),
    .load_n (load_n),
    .addr_q (addr_q),
    .din_q  (din_q),
    .op_q   (op_q)
  );

  tag_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
    .clk   (clk),
    .we    (op_q == OP_WRITE),
    .addr  (addr_q),
    .wdata (din_q),
    .rword (rword)
  );

  tag_compare #(.DW(DATA_W)) u_cmp (
    .clk   (clk),
    .rst   (rst),
    .key   (din_q),
    .word  (rword),
    .hit_q (hit_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                  dout_q <= '0;
    else if (op_q == OP_READ) dout_q <= rword;
  end

  assign dout_vld  = !oe_n;
  assign dout      = oe_n ? '0 : dout_q;
  assign match_vld = !match_oe_n;
  assign match     = match_oe_n ? 1'b0 : hit_q;

endmodule

// File: rtl/tag_cache_ram_chk.sv
module tag_cache_ram_chk
  import tag_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          sel_n,
  input logic          sel_hi,
  input logic          load_n,
  input logic [AW-1:0] addr_q,
  input logic [DW-1:0] din_q,
  input tag_op_e       op_q,
  input logic [DW-1:0] rword,
  input logic          hit_q,
  input logic [DW-1:0] dout_q
);

  // R1
  desel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(chip_selected(sel_n, sel_hi)) |-> ($stable(addr_q) && op_q == OP_IDLE));

  // R2
  tag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(chip_selected(sel_n, sel_hi) && !load_n) |-> $stable(din_q));

  // R3
  write_land_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(op_q == OP_WRITE) && $stable(addr_q)) |-> (rword == $past(din_q)));

  // R5
  match_pipe_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (hit_q == ($past(din_q) == $past(rword))));

  // R6
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(op_q) != OP_READ) |-> $stable(dout_q));

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!hit_q && dout_q == '0));

endmodule

bind tag_cache_ram tag_cache_ram_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .sel_n  (sel_n),
  .sel_hi (sel_hi),
  .load_n (load_n),
  .addr_q (addr_q),
  .din_q  (din_q),
  .op_q   (op_q),
  .rword  (rword),
  .hit_q  (hit_q),
  .dout_q (dout_q)
);

// File: tb/tag_cache_ram_test.sv
module tag_cache_ram_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 18;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic          wr_n = 1'b1, sel_n = 1'b1, sel_hi = 1'b0, load_n = 1'b1;
  logic          oe_n = 1'b1, match_oe_n = 1'b1;
  logic [DW-1:0] dout;
  logic          dout_vld, match, match_vld;

  tag_cache_ram #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .addr(addr), .din(din), .wr_n(wr_n),
    .sel_n(sel_n), .sel_hi(sel_hi), .load_n(load_n), .oe_n(oe_n),
    .match_oe_n(match_oe_n), .dout(dout), .dout_vld(dout_vld),
    .match(match), .match_vld(match_vld)
  );

  int vectors = 0;
  int fails = 0;
  bit chk_match = 0;

  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] ref_din = '0;
  logic [AW-1:0] ref_addr = '0;
  logic [DW-1:0] ref_dout = '0;
  bit ref_wp = 0, ref_rp = 0, ref_match = 0;

  function automatic logic [DW-1:0] gated(input bit en_n, input logic [DW-1:0] w);
    return en_n ? '0 : w;
  endfunction

  function automatic logic [DW-1:0] init_word(input int i);
    return DW'((i * 7919 + 5) ^ (i << 9));
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit wrn,
                      input bit seln, input bit selh, input bit ldn,
                      input bit oen, input bit moen);
    logic [DW-1:0] old;
    bit sel;
    addr = a; din = d; wr_n = wrn; sel_n = seln; sel_hi = selh; load_n = ldn;
    oe_n = oen; match_oe_n = moen;
    @(posedge clk);
    sel = !seln && selh;
    old = ref_mem[ref_addr];
    if (ref_wp) ref_mem[ref_addr] = ref_din;
    if (rst) begin
      ref_wp = 0; ref_rp = 0; ref_match = 0; ref_dout = '0;
    end else begin
      ref_match = (ref_din == old);
      if (ref_rp) ref_dout = old;
      if (sel) ref_addr = a;
      if (sel && !ldn) ref_din = d;
      ref_wp = sel && !wrn;
      ref_rp = sel && wrn;
    end
    @(negedge clk);
    check("R7 dout", dout, gated(oen, ref_dout));
    check("R7 dout_vld", DW'(dout_vld), DW'(!oen));
    check("R8 match_vld", DW'(match_vld), DW'(!moen));
    if (chk_match) check("R5/R8 match", DW'(match), DW'(moen ? 1'b0 : ref_match));
  endtask

  task automatic idle(input bit moen);
    step('0, '0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, moen);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    void'($urandom(32'd20251));
    @(negedge clk);
    // R9: reset state
    for (int i = 0; i < 3; i++) idle(1'b0);
    check("R9 reset dout", dout, '0);
    check("R9 reset match", DW'(match), '0);
    rst = 1'b0;

    // R3: fill the array through normal writes
    for (int i = 0; i < DEPTH; i++)
      step(AW'(i), init_word(i), 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    idle(1'b1);
    idle(1'b1);
    chk_match = 1;

    // R5: hit, one edge of latency
    step(AW'(3), ref_mem[3], 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(1'b0);
    check("R5 hit after one edge", DW'(match), DW'(1));
    // R5: miss
    step(AW'(3), ref_mem[3] ^ DW'(1), 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(1'b0);
    check("R5 miss", DW'(match), DW'(0));

    // R2: load held off, tag register keeps a matching value
    step(AW'(5), ref_mem[5], 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    step(AW'(5), ~ref_mem[5], 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    idle(1'b0);
    check("R2 held tag still hits", DW'(match), DW'(1));

    // R4: fill write stores the held tag, not din
    held = ref_mem[7];
    step(AW'(7), held, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    step(AW'(9), ~held, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    step(AW'(9), '0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    idle(1'b0);
    check("R4 fill wrote held tag", dout, held);

    // R1: writes attempted while deselected by either line
    step(AW'(10), '1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    step(AW'(11), '1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(AW'(10), '0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    idle(1'b0);
    check("R1 entry 10 untouched", dout, init_word(10));
    step(AW'(11), '0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    idle(1'b0);
    check("R1 entry 11 untouched", dout, init_word(11));
    // R6/R8: output holds and match still shown while deselected
    idle(1'b0);
    check("R6 dout holds", dout, init_word(11));

    // Constrained random traffic over a few entries
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = AW'($urandom_range(0, 7));
      d = ($urandom_range(0, 1) == 1) ? ref_mem[a] : DW'($urandom);
      step(a, d, 1'($urandom), ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) != 0),
           1'($urandom), 1'($urandom), 1'($urandom));
    end
    idle(1'b0);
    idle(1'b0);

    // R9: reset mid-run keeps array contents
    held = ref_mem[3];
    rst = 1'b1;
    idle(1'b0);
    idle(1'b0);
    check("R9 match cleared", DW'(match), '0);
    check("R9 dout cleared", uut.dout_vld ? dout : '1, '0);
    rst = 1'b0;
    step(AW'(3), '0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    idle(1'b0);
    check("R9 array kept", dout, held);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule